// File: doc/BRIEF.md
# Thermal throttle controller

This block is the on-die control loop that throttles a core when its temperature passes the maximum operating limit. A single comparator flag reports over-temperature. Once the flag is seen, the block becomes active. It leaves that state only after the temperature has stayed below the limit for a hysteresis interval, counted in ticks of a fixed 1 MHz reference. If the temperature climbs back over the limit during that interval, the count starts again.

While the block is active and the frequency and voltage targets are already at their floor, it gates the core clock with a fixed duty cycle. Each period is 32 reference ticks long, with the enable high for the first 8 ticks. Gating switches on or off only at a period boundary, so an on-window is never cut short.

Software performance-state changes arrive as a ratio with a strobe. Outside a thermal event a request is applied at once. During an event the block applies a request whose ratio does not exceed the thermally optimized target, and holds back any higher request until the event is over.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `therm_active` is 0, `clk_gate_en` is 1 and `applied_ratio` equals `RESET_RATIO` (default 24). The duty phase counter restarts at phase 0.
- R2: When `over_temp` is sampled high at a clock edge, `therm_active` is 1 after that edge.
- R3: Once `over_temp` is sampled low while active, `therm_active` stays 1 until `HYST_TICKS` (default 16) ticks have been sampled with `over_temp` low. It drops after the edge that samples the last of those ticks, and it never falls on an edge without a tick.
- R4: If `over_temp` is sampled high before the hysteresis count completes, the count restarts from zero, and a full `HYST_TICKS` ticks of low temperature are again needed before `therm_active` drops.
- R5: The duty phase advances by one on each sampled tick, modulo `PERIOD_TICKS` (default 32). While gating is in force, `clk_gate_en` is 1 in phases 0 to `ON_TICKS`-1 (default 0..7) and 0 in the other phases, giving 8 high ticks per 32. `clk_gate_en` never changes on an edge without a tick.
- R6: Gating is re-evaluated only on the tick that wraps the phase from `PERIOD_TICKS`-1 to 0. It becomes in force only if `therm_active` and `at_floor` are both 1 at that edge. When gating is not in force, `clk_gate_en` is 1.
- R7: A strobe on `req_valid` while `therm_active` is 0 sets `applied_ratio` to `req_ratio` after that edge.
- R8: A strobe while `therm_active` is 1 with `req_ratio` greater than `opt_ratio` leaves `applied_ratio` unchanged and stores the request as pending.
- R9: A strobe while `therm_active` is 1 with `req_ratio` not greater than `opt_ratio` sets `applied_ratio` to `req_ratio` after that edge and discards any pending request.
- R10: Only one request is held pending; a newer held request replaces an older one.
- R11: A pending request is applied on the edge after the one at which `therm_active` falls; `applied_ratio` is unchanged right after the fall itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | One-cycle pulse from the fixed 1 MHz reference |
| over_temp | input | 1 | Temperature above the maximum operating limit |
| at_floor | input | 1 | Frequency and voltage targets are at their minimum |
| req_valid | input | 1 | Performance-state request strobe |
| req_ratio | input | 8 | Requested frequency ratio |
| opt_ratio | input | 8 | Thermally optimized target ratio |
| clk_gate_en | output | 1 | Core clock enable |
| therm_active | output | 1 | Thermal control in force |
| applied_ratio | output | 8 | Ratio currently applied to the core |

## Verification
Every result appears after a known clock edge:
- `therm_active` rises after the edge that samples `over_temp`.
- `therm_active` falls after the edge that samples the final hysteresis tick.
- A strobed ratio shows on `applied_ratio` after its own edge.
- A held ratio shows one edge after `therm_active` falls.
- The gate state changes only on the wrap tick.

The bench drives every input on a falling edge, with a tick lasting exactly one rising edge. It reads outputs on the next falling edge, and it tracks the duty phase by counting the ticks it has issued since reset. Hysteresis and duty checks are made at the tick just before and just after each expected transition, so an off-by-one in any counter shows up.

// File: rtl/thr_pkg.sv
package thr_pkg;

    // Width of every frequency ratio carried by the block.
    parameter int unsigned RATIO_BITS = 8;

    typedef logic [RATIO_BITS-1:0] ratio_t;

    // Control loop state: idle, above limit, or counting down hysteresis.
    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_HOT  = 2'd1,
        TS_COOL = 2'd2
    } therm_state_e;

    // A held-back performance request.
    typedef struct packed {
        logic   valid;
        ratio_t ratio;
    } held_req_t;

    // True when a request must wait for the thermal event to end.
    function automatic logic ratio_exceeds(input ratio_t req, input ratio_t target);
        return req > target;
    endfunction

    // True when the given duty phase lies inside the on-window.
    function automatic logic in_on_window(input int unsigned phase,
                                          input int unsigned on_len);
        return phase < on_len;
    endfunction

endpackage

// File: rtl/thr_hyst_fsm.sv
module thr_hyst_fsm
    import thr_pkg::*;
#(
    parameter int unsigned HYST_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic over_temp,
    output logic active
);
    localparam int unsigned CW = (HYST_TICKS > 1) ? $clog2(HYST_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HYST_TICKS - 1);

    therm_state_e state_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TS_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                TS_IDLE: begin
                    if (over_temp) begin
                        state_q <= TS_HOT;
                    end
                end
                TS_HOT: begin
                    if (!over_temp) begin
                        state_q <= TS_COOL;
                        cnt_q   <= '0;
                    end
                end
                TS_COOL: begin
                    if (over_temp) begin
                        // Reheat before expiry: reload and keep control on.
                        state_q <= TS_HOT;
                        cnt_q   <= '0;
                    end else if (tick) begin
                        if (cnt_q == LAST) begin
                            state_q <= TS_IDLE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                end
                default: begin
                    state_q <= TS_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign active = (state_q != TS_IDLE);

endmodule

// File: rtl/thr_duty_gen.sv
module thr_duty_gen
    import thr_pkg::*;
#(
    parameter int unsigned PERIOD_TICKS = 32,
    parameter int unsigned ON_TICKS     = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic want_gate,
    output logic clk_en
);
    localparam int unsigned PW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(PERIOD_TICKS - 1);

    logic [PW-1:0] phase_q;
    logic          gating_q;
    logic          wrap;

    assign wrap = tick && (phase_q == LAST);

    // Phase runs from the fixed reference regardless of the gate state.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= wrap ? '0 : phase_q + PW'(1);
        end
    end

    // Gate decision latched only where a new period starts.
    always_ff @(posedge clk) begin
        if (rst) begin
            gating_q <= 1'b0;
        end else if (wrap) begin
            gating_q <= want_gate;
        end
    end

    generate
        if (ON_TICKS >= PERIOD_TICKS) begin : g_always_on
            assign clk_en = 1'b1;
        end else begin : g_windowed
            assign clk_en = !gating_q ||
                            in_on_window(int'(phase_q), ON_TICKS);
        end
    endgenerate

endmodule

// File: rtl/thr_ratio_arb.sv
module thr_ratio_arb
    import thr_pkg::*;
#(
    parameter ratio_t RESET_RATIO = 8'd24
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   active,
    input  logic   req_valid,
    input  ratio_t req_ratio,
    input  ratio_t opt_ratio,
    output ratio_t applied
);
    held_req_t held_q;
    logic      active_q;
    ratio_t    applied_q;
    logic      event_over;

    assign event_over = active_q && !active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
        end else begin
            active_q <= active;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q    <= '0;
            applied_q <= RESET_RATIO;
        end else if (req_valid) begin
            if (active && ratio_exceeds(req_ratio, opt_ratio)) begin
                // Upward move during an event: park it, newest wins.
                held_q.valid <= 1'b1;
                held_q.ratio <= req_ratio;
            end else begin
                applied_q    <= req_ratio;
                held_q.valid <= 1'b0;
            end
        end else if (event_over && held_q.valid) begin
            applied_q    <= held_q.ratio;
            held_q.valid <= 1'b0;
        end
    end

    assign applied = applied_q;

endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
    import thr_pkg::*;
#(
    parameter int unsigned PERIOD_TICKS = 32,
    parameter int unsigned ON_TICKS     = 8,
    parameter int unsigned HYST_TICKS   = 16,
    parameter ratio_t      RESET_RATIO  = 8'd24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_1us,
    input  logic                  over_temp,
    input  logic                  at_floor,
    input  logic                  req_valid,
    input  logic [RATIO_BITS-1:0] req_ratio,
    input  logic [RATIO_BITS-1:0] opt_ratio,
    output logic                  clk_gate_en,
    output logic                  therm_active,
    output logic [RATIO_BITS-1:0] applied_ratio
);
    logic active;

    thr_hyst_fsm #(
        .HYST_TICKS(HYST_TICKS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1us),
        .over_temp(over_temp),
        .active   (active)
    );

    thr_duty_gen #(
        .PERIOD_TICKS(PERIOD_TICKS),
        .ON_TICKS    (ON_TICKS)
    ) u_duty (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1us),
        .want_gate(active && at_floor),
        .clk_en   (clk_gate_en)
    );

    thr_ratio_arb #(
        .RESET_RATIO(RESET_RATIO)
    ) u_arb (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .req_valid(req_valid),
        .req_ratio(req_ratio),
        .opt_ratio(opt_ratio),
        .applied  (applied_ratio)
    );

    assign therm_active = active;

endmodule

// File: rtl/thr_ctrl_checker.sv
module thr_ctrl_checker
    import thr_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   tick_1us,
    input logic   over_temp,
    input logic   req_valid,
    input ratio_t req_ratio,
    input ratio_t opt_ratio,
    input logic   clk_gate_en,
    input logic   therm_active,
    input ratio_t applied_ratio
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!therm_active && clk_gate_en));

    p_enter_r2: assert property (@(posedge clk) disable iff (rst)
        over_temp |=> therm_active);

    p_exit_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (therm_active && !tick_1us) |=> therm_active);

    p_gate_tick_only_r5: assert property (@(posedge clk) disable iff (rst)
        !tick_1us |=> $stable(clk_gate_en));

    p_idle_apply_r7: assert property (@(posedge clk) disable iff (rst)
        (!therm_active && req_valid) |=> (applied_ratio == $past(req_ratio)));

    p_hold_high_r8: assert property (@(posedge clk) disable iff (rst)
        (therm_active && req_valid && (req_ratio > opt_ratio))
        |=> $stable(applied_ratio));

    p_low_apply_r9: assert property (@(posedge clk) disable iff (rst)
        (therm_active && req_valid && (req_ratio <= opt_ratio))
        |=> (applied_ratio == $past(req_ratio)));

endmodule

bind thermal_throttle_ctrl thr_ctrl_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_1us     (tick_1us),
    .over_temp    (over_temp),
    .req_valid    (req_valid),
    .req_ratio    (req_ratio),
    .opt_ratio    (opt_ratio),
    .clk_gate_en  (clk_gate_en),
    .therm_active (therm_active),
    .applied_ratio(applied_ratio)
);

// File: tb/sim_thermal_throttle_ctrl.sv
`timescale 1ns/1ps
module sim_thermal_throttle_ctrl;
    localparam int PERIOD = 32;
    localparam int ON     = 8;
    localparam int HYST   = 16;
    localparam int RST_R  = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1us = 1'b0;
    logic       over_temp = 1'b0;
    logic       at_floor = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_ratio = '0;
    logic [7:0] opt_ratio = 8'd20;
    logic       clk_gate_en;
    logic       therm_active;
    logic [7:0] applied_ratio;

    int n_checks = 0;
    int n_fail   = 0;
    int tcnt     = 0;

    always #5 clk = ~clk;

    thermal_throttle_ctrl u0 (
        .clk          (clk),
        .rst          (rst),
        .tick_1us     (tick_1us),
        .over_temp    (over_temp),
        .at_floor     (at_floor),
        .req_valid    (req_valid),
        .req_ratio    (req_ratio),
        .opt_ratio    (opt_ratio),
        .clk_gate_en  (clk_gate_en),
        .therm_active (therm_active),
        .applied_ratio(applied_ratio)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_tick();
        tick_1us = 1'b1;
        @(negedge clk);
        tick_1us = 1'b0;
        tcnt++;
    endtask

    task automatic to_boundary();
        while (tcnt % PERIOD != 0) do_tick();
    endtask

    task automatic send_req(input int r);
        req_valid = 1'b1;
        req_ratio = 8'(r);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic cool_and_exit();
        over_temp = 1'b0;
        step();
        repeat (HYST) do_tick();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        chk("R1 active in reset", therm_active, 0);
        rst = 1'b0;
        tcnt = 0;
        step();
        chk("R1 active after reset", therm_active, 0);
        chk("R1 gate after reset", clk_gate_en, 1);
        chk("R1 ratio after reset", applied_ratio, RST_R);
    endtask

    task automatic t_enter_exit();
        over_temp = 1'b1;
        step();
        chk("R2 active after hot", therm_active, 1);
        over_temp = 1'b0;
        repeat (4) step();
        chk("R3 active without ticks", therm_active, 1);
        repeat (HYST - 1) do_tick();
        chk("R3 active one tick early", therm_active, 1);
        do_tick();
        chk("R3 inactive at expiry", therm_active, 0);
    endtask

    task automatic t_reload();
        over_temp = 1'b1;
        step();
        over_temp = 1'b0;
        step();
        repeat (HYST - 2) do_tick();
        over_temp = 1'b1;
        step();
        over_temp = 1'b0;
        step();
        repeat (HYST - 1) do_tick();
        chk("R4 still active after reload", therm_active, 1);
        do_tick();
        chk("R4 inactive after full reload", therm_active, 0);
    endtask

    task automatic t_gating();
        int bad = 0;
        int highs = 0;
        over_temp = 1'b1;
        at_floor  = 1'b0;
        step();
        to_boundary();
        for (int i = 0; i < PERIOD; i++) begin
            if (clk_gate_en !== 1'b1) bad++;
            do_tick();
        end
        chk("R6 no gating above floor", bad, 0);
        at_floor = 1'b1;
        bad = 0;
        for (int i = 0; i < PERIOD; i++) begin
            if (clk_gate_en !== 1'b1) bad++;
            do_tick();
        end
        chk("R6 no gating before boundary", bad, 0);
        bad = 0;
        for (int i = 0; i < PERIOD; i++) begin
            if (clk_gate_en !== ((tcnt % PERIOD) < ON)) bad++;
            if (clk_gate_en === 1'b1) highs++;
            if (i == 9) begin
                repeat (3) step();
                if (clk_gate_en !== 1'b0) bad++;
            end
            do_tick();
        end
        chk("R5 duty pattern", bad, 0);
        chk("R5 on ticks per period", highs, ON);
        while (tcnt % PERIOD != 10) do_tick();
        at_floor = 1'b0;
        step();
        chk("R6 gating held to boundary", clk_gate_en, 0);
        to_boundary();
        chk("R6 gating released at boundary", clk_gate_en, 1);
        do_tick();
        chk("R6 gating stays released", clk_gate_en, 1);
        cool_and_exit();
        chk("R3 exit after gating test", therm_active, 0);
    endtask

    task automatic t_ratio_idle();
        send_req(30);
        chk("R7 idle request applied", applied_ratio, 30);
        send_req(50);
        chk("R7 idle upward request applied", applied_ratio, 50);
    endtask

    task automatic t_ratio_active();
        opt_ratio = 8'd20;
        over_temp = 1'b1;
        step();
        send_req(10);
        chk("R9 lower request applied", applied_ratio, 10);
        send_req(20);
        chk("R9 equal request applied", applied_ratio, 20);
        send_req(40);
        chk("R8 higher request held", applied_ratio, 20);
        send_req(35);
        chk("R8 second higher request held", applied_ratio, 20);
        over_temp = 1'b0;
        step();
        repeat (HYST - 1) do_tick();
        chk("R11 still held before exit", applied_ratio, 20);
        do_tick();
        chk("R11 active dropped", therm_active, 0);
        chk("R11 unchanged on fall edge", applied_ratio, 20);
        step();
        chk("R10 newest held request applied", applied_ratio, 35);
        step();
        chk("R11 value stays", applied_ratio, 35);
        over_temp = 1'b1;
        step();
        send_req(60);
        chk("R8 held again", applied_ratio, 35);
        send_req(15);
        chk("R9 lower request applied", applied_ratio, 15);
        cool_and_exit();
        step();
        step();
        chk("R9 pending discarded", applied_ratio, 15);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_enter_exit();
        t_reload();
        t_gating();
        t_ratio_idle();
        t_ratio_active();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule